// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Controller

This block holds the clock-enable and reset state for a set of peripheral consumers and exposes that state through a small 16-bit register bus. The consumers are split into three groups. Each group has a reset register, an enable-status register, a write-to-set enable strobe and a write-to-clear enable strobe. Each consumer drives one clock-enable output, which a gating cell elsewhere in the chip uses, and one reset output.

Software turns a clock on by writing a one to that consumer's bit in the group's set strobe. It turns the clock off by writing a one to the same bit in the clear strobe. A zero bit in either strobe leaves that consumer as it is. Some consumers are hardware-controlled: their enable follows a demand input and ignores the strobes. Others have no enable at all and always report running. Every consumer comes out of power-up held in reset, and software must release it by writing its reset register.

The bus has no wait states. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is returned in the same cycle as the address.

The bus address has two fields. `bus_addr[1:0]` selects the group (0, 1 or 2; 3 is unmapped). `bus_addr[3:2]` selects the register kind: 0 is reset, 1 is status (read-only), 2 is set and 3 is clear. Consumer `i` of group `g` sits at bit `i` of that group's registers and at index `g*GRP_W+i` of the flat output vectors.

Top module: `pcg_ctrl`

## Requirements
- R1: After reset every bit of `periph_rst` is 1. No software enable is set, so `clk_en` equals the always-on mask ORed with the hardware-demanded bits.
- R2: A write to a group's set register (kind 2) turns on each software-gated consumer whose data bit is 1. The change appears on `clk_en` one cycle after the write. Bits written as 0, and all other groups, are unchanged.
- R3: A write to a group's clear register (kind 3) turns off each software-gated consumer whose data bit is 1. Bits written as 0 are unchanged.
- R4: A write to a group's reset register (kind 0) loads that group's `periph_rst` bits from the data: 1 holds the consumer in reset and 0 releases it. A read returns the stored value. Such a write never changes `clk_en`.
- R5: A read of a group's status register (kind 1) returns that group's `clk_en` bits in bits `GRP_W-1:0`. Bits above these read as 0.
- R6: Reads of the set and clear registers return 0.
- R7: For a hardware-controlled consumer, `clk_en` equals its `hw_req` bit. Set and clear writes have no effect on it.
- R8: An always-on consumer has `clk_en` at 1 and status 1 regardless of set and clear writes. Its reset bit is still writable.
- R9: Writes to status registers, and any access with group field 3, change nothing. Reads with group field 3 return 0.
- R10: `periph_rst` is registered. It changes only at the clock edge after a reset-register write, never within the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | {kind[1:0], group[1:0]} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle, 0 when not reading |
| hw_req | input | 3*GRP_W | Hardware clock demand (used by hardware-controlled consumers only) |
| clk_en | output | 3*GRP_W | Per-consumer clock enable |
| periph_rst | output | 3*GRP_W | Per-consumer reset, 1 = held |

## Verification
Corrupt enable state shows on `clk_en` at the next clock edge after the offending write, and on the status readback in the same cycle as the read. The bench compares both against its own model after every access. A reset bit that is lost or inverted appears on `periph_rst` and in the reset readback right away. A misdecoded address instead shows a change in some other group's outputs, so every scenario rechecks all consumers and not only the group it targets. For masked consumers, any leak from the strobes shows as a `clk_en` bit that moves without a matching change on `hw_req`.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int GRP_NUM = 3;
    localparam int REG_W   = 16;
    localparam int DEF_GRP_W = 12;
    // defaults for 3 groups of 12: hardware control on bit 0 of each group,
    // always-on at group 2 bit 6
    localparam logic [GRP_NUM*DEF_GRP_W-1:0] DEF_HW_MASK  = 36'h0_0100_1001;
    localparam logic [GRP_NUM*DEF_GRP_W-1:0] DEF_AON_MASK = 36'h0_4000_0000;

    typedef enum logic [1:0] {
        KIND_RST  = 2'd0,
        KIND_STAT = 2'd1,
        KIND_SET  = 2'd2,
        KIND_CLR  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
    import pcg_pkg::*;
(
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [3:0]         bus_addr,
    output reg_kind_e          kind,
    output logic [GRP_NUM-1:0] grp_hit,
    output logic [GRP_NUM-1:0] wr_rst,
    output logic [GRP_NUM-1:0] wr_set,
    output logic [GRP_NUM-1:0] wr_clr
);
    logic wr_cyc;

    assign kind   = reg_kind_e'(bus_addr[3:2]);
    assign wr_cyc = bus_sel && bus_wr;

    for (genvar g = 0; g < GRP_NUM; g++) begin : g_hit
        assign grp_hit[g] = (bus_addr[1:0] == 2'(g));
        assign wr_rst[g]  = wr_cyc && grp_hit[g] && (kind == KIND_RST);
        assign wr_set[g]  = wr_cyc && grp_hit[g] && (kind == KIND_SET);
        assign wr_clr[g]  = wr_cyc && grp_hit[g] && (kind == KIND_CLR);
    end
endmodule

// File: rtl/pcg_group.sv
module pcg_group #(
    parameter int           W        = 12,
    parameter logic [W-1:0] HW_MASK  = '0,
    parameter logic [W-1:0] AON_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_rst,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_req,
    output logic [W-1:0] clk_en,
    output logic [W-1:0] rst_out
);
    logic grp_unused;

    // reset holding register: all consumers held after power-up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_out <= '1;
        end else if (wr_rst) begin
            rst_out <= wdata;
        end
    end

    // each consumer bit picks its enable variant
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (AON_MASK[i]) begin : g_aon
            assign clk_en[i] = 1'b1;
        end else if (HW_MASK[i]) begin : g_hw
            assign clk_en[i] = hw_req[i];
        end else begin : g_soft
            logic en_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q <= 1'b0;
                end else if (wr_clr && wdata[i]) begin
                    en_q <= 1'b0;
                end else if (wr_set && wdata[i]) begin
                    en_q <= 1'b1;
                end
            end
            assign clk_en[i] = en_q;
        end
    end

    assign grp_unused = ^(hw_req & ~HW_MASK);
endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
    import pcg_pkg::*;
#(
    parameter int                       GRP_W          = DEF_GRP_W,
    parameter logic [GRP_NUM*GRP_W-1:0] HW_CTRL_MASK   = DEF_HW_MASK,
    parameter logic [GRP_NUM*GRP_W-1:0] ALWAYS_ON_MASK = DEF_AON_MASK
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [3:0]               bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    input  logic [GRP_NUM*GRP_W-1:0] hw_req,
    output logic [GRP_NUM*GRP_W-1:0] clk_en,
    output logic [GRP_NUM*GRP_W-1:0] periph_rst
);
    localparam int NCONS = GRP_NUM * GRP_W;

    reg_kind_e          kind;
    logic [GRP_NUM-1:0] grp_hit;
    logic [GRP_NUM-1:0] wr_rst;
    logic [GRP_NUM-1:0] wr_set;
    logic [GRP_NUM-1:0] wr_clr;
    logic [GRP_W-1:0]   grp_rst [GRP_NUM];
    logic [GRP_W-1:0]   grp_en  [GRP_NUM];
    logic [GRP_W-1:0]   sel_rst;
    logic [GRP_W-1:0]   sel_en;
    logic               any_hit;

    pcg_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .kind     (kind),
        .grp_hit  (grp_hit),
        .wr_rst   (wr_rst),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr)
    );

    for (genvar g = 0; g < GRP_NUM; g++) begin : g_grp
        pcg_group #(
            .W        (GRP_W),
            .HW_MASK  (HW_CTRL_MASK[g*GRP_W +: GRP_W]),
            .AON_MASK (ALWAYS_ON_MASK[g*GRP_W +: GRP_W])
        ) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_rst  (wr_rst[g]),
            .wr_set  (wr_set[g]),
            .wr_clr  (wr_clr[g]),
            .wdata   (bus_wdata[GRP_W-1:0]),
            .hw_req  (hw_req[g*GRP_W +: GRP_W]),
            .clk_en  (grp_en[g]),
            .rst_out (grp_rst[g])
        );
        assign clk_en[g*GRP_W +: GRP_W]     = grp_en[g];
        assign periph_rst[g*GRP_W +: GRP_W] = grp_rst[g];
    end

    if (GRP_W < REG_W) begin : g_pad
        logic wdata_unused;
        assign wdata_unused = ^bus_wdata[REG_W-1:GRP_W];
    end

    // group selection for readback
    always_comb begin
        sel_rst = '0;
        sel_en  = '0;
        any_hit = 1'b0;
        for (int g = 0; g < GRP_NUM; g++) begin
            if (grp_hit[g]) begin
                sel_rst = grp_rst[g];
                sel_en  = grp_en[g];
                any_hit = 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && any_hit) begin
            unique case (kind)
                KIND_RST:  bus_rdata = REG_W'(sel_rst);
                KIND_STAT: bus_rdata = REG_W'(sel_en);
                KIND_SET:  bus_rdata = '0;
                KIND_CLR:  bus_rdata = '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    logic [NCONS-1:0] width_unused;
    assign width_unused = '0;
endmodule

// File: rtl/pcg_ctrl_chk.sv
module pcg_ctrl_chk
    import pcg_pkg::*;
#(
    parameter int                       GRP_W          = DEF_GRP_W,
    parameter logic [GRP_NUM*GRP_W-1:0] HW_CTRL_MASK   = DEF_HW_MASK,
    parameter logic [GRP_NUM*GRP_W-1:0] ALWAYS_ON_MASK = DEF_AON_MASK
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [3:0]               bus_addr,
    input logic [15:0]              bus_wdata,
    input logic [15:0]              bus_rdata,
    input logic [GRP_NUM*GRP_W-1:0] hw_req,
    input logic [GRP_NUM*GRP_W-1:0] clk_en,
    input logic [GRP_NUM*GRP_W-1:0] periph_rst
);
    localparam logic [GRP_NUM*GRP_W-1:0] SOFT = ~(HW_CTRL_MASK | ALWAYS_ON_MASK);

    logic chk_unused;
    assign chk_unused = ^bus_wdata;

    // R2
    soft_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|((clk_en & SOFT) & ~$past(clk_en & SOFT)))
        |-> $past(bus_sel && bus_wr && bus_addr[3:2] == 2'd2));

    // R3
    soft_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~(clk_en & SOFT) & $past(clk_en & SOFT)))
        |-> $past(bus_sel && bus_wr && bus_addr[3:2] == 2'd3));

    // R7
    hw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en & HW_CTRL_MASK) == (hw_req & HW_CTRL_MASK));

    // R8
    always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en & ALWAYS_ON_MASK) == ALWAYS_ON_MASK);

    // R6
    strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[3]) |-> (bus_rdata == 16'h0000));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[1:0] == 2'd3) |-> (bus_rdata == 16'h0000));

    // R10
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(periph_rst) |-> $past(bus_sel && bus_wr && bus_addr[3:2] == 2'd0));
endmodule

bind pcg_ctrl pcg_ctrl_chk #(
    .GRP_W          (GRP_W),
    .HW_CTRL_MASK   (HW_CTRL_MASK),
    .ALWAYS_ON_MASK (ALWAYS_ON_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .hw_req     (hw_req),
    .clk_en     (clk_en),
    .periph_rst (periph_rst)
);

// File: tb/pcg_ctrl_tb.sv
module pcg_ctrl_tb;
    import pcg_pkg::*;

    localparam int GW = DEF_GRP_W;
    localparam int NC = GRP_NUM * GW;
    localparam logic [NC-1:0] HWM = DEF_HW_MASK;
    localparam logic [NC-1:0] AON = DEF_AON_MASK;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [NC-1:0] hw_req = '0;
    logic [NC-1:0] clk_en;
    logic [NC-1:0] periph_rst;

    logic [NC-1:0] m_soft = '0;
    logic [NC-1:0] m_rst  = '1;
    int errors = 0;
    int checks = 0;
    logic [15:0] rd;

    always #5 clk = ~clk;

    pcg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_req(hw_req), .clk_en(clk_en), .periph_rst(periph_rst)
    );

    function automatic logic [3:0] ad(input int kind, input int grp);
        return {2'(kind), 2'(grp)};
    endfunction

    function automatic logic [NC-1:0] exp_en();
        return AON | (HWM & hw_req) | (m_soft & ~HWM & ~AON);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req);
        chk(req, 64'(clk_en), 64'(exp_en()));
        chk(req, 64'(periph_rst), 64'(m_rst));
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk_outs("R1");
        chk("R1 en", 64'(clk_en), 64'(AON));
        bus_read(ad(0, 0), rd);
        chk("R1 rstreg", 64'(rd), 64'h0FFF);
    endtask

    task automatic t_set();
        bus_write(ad(2, 0), 16'h0006);
        m_soft[2:1] = 2'b11;
        chk_outs("R2 g0");
        bus_write(ad(2, 1), 16'h0020);
        m_soft[GW+5] = 1'b1;
        chk_outs("R2 g1");
        bus_read(ad(1, 0), rd);
        chk("R5 stat g0", 64'(rd), 64'h0006);
        bus_read(ad(1, 1), rd);
        chk("R5 stat g1", 64'(rd), 64'h0020);
    endtask

    task automatic t_clear();
        bus_write(ad(3, 0), 16'h0002);
        m_soft[1] = 1'b0;
        chk_outs("R3 clr");
        bus_write(ad(3, 1), 16'h0000);
        chk_outs("R3 zero");
        bus_read(ad(1, 0), rd);
        chk("R3 stat", 64'(rd), 64'h0004);
    endtask

    task automatic t_strobe_read();
        bus_read(ad(2, 0), rd);
        chk("R6 set", 64'(rd), 64'h0);
        bus_read(ad(3, 1), rd);
        chk("R6 clr", 64'(rd), 64'h0);
    endtask

    task automatic t_hw();
        bus_write(ad(2, 0), 16'h0001);
        chk_outs("R7 set ignored");
        @(negedge clk);
        hw_req[0] = 1'b1;
        hw_req[5] = 1'b1;
        #1;
        chk_outs("R7 demand");
        bus_write(ad(3, 0), 16'h0001);
        chk_outs("R7 clr ignored");
        bus_read(ad(1, 0), rd);
        chk("R7 stat", 64'(rd), 64'h0005);
        @(negedge clk);
        hw_req = '0;
        #1;
        chk_outs("R7 drop");
    endtask

    task automatic t_aon();
        bus_write(ad(3, 2), 16'h0040);
        chk_outs("R8 clr");
        bus_read(ad(1, 2), rd);
        chk("R8 stat", 64'(rd), 64'h0040);
        bus_write(ad(0, 2), 16'h0000);
        m_rst[3*GW-1:2*GW] = '0;
        chk_outs("R8 rst");
    endtask

    task automatic t_rst();
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad(0, 1); bus_wdata = 16'h0F0F;
        #1;
        chk("R10 before edge", 64'(periph_rst), 64'(m_rst));
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
        m_rst[2*GW-1:GW] = 12'hF0F;
        chk_outs("R4 write");
        bus_read(ad(0, 1), rd);
        chk("R4 readback", 64'(rd), 64'h0F0F);
    endtask

    task automatic t_ignored();
        bus_write(ad(1, 0), 16'hFFFF);
        chk_outs("R9 stat write");
        bus_write(ad(0, 3), 16'h0000);
        bus_write(ad(2, 3), 16'hFFFF);
        chk_outs("R9 grp3 write");
        bus_read(ad(0, 3), rd);
        chk("R9 grp3 read", 64'(rd), 64'h0);
        bus_read(ad(1, 3), rd);
        chk("R9 grp3 stat", 64'(rd), 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_set();
        t_clear();
        t_strobe_read();
        t_hw();
        t_aon();
        t_rst();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule